// File: doc/BRIEF.md
# Monochrome Composite Raster Timing Generator

The block produces a non-interlaced black-and-white composite video frame as a 3-bit level code. The code drives an external resistor network that forms the analog signal. A frame is a fixed sequence of lines, each of nominal 63.55 µs. The vertical interval is made of lines that carry two half-line sync patterns. It is followed by blank lines that hold only horizontal sync. After that come picture lines with a front porch, a sync pulse, a back porch and an image segment.

A band of image lines is centred in the usable picture region. On those lines the block pulls 2-bit gray pixels from a pixel source with a request/ready handshake and converts each one to a level code. Picture lines outside the band are sent at black. Every duration is derived from a clock-frequency parameter and rounded to whole cycles, so the same RTL serves any clock that is fast enough. Line-start and frame-start strobes let a frame buffer or pixel source keep its own addressing in step.

Top module: `ntsc_mono_raster`

## Requirements
- R1: While rst_ni is low, code_o is 001 (blank) and line_start_o, frame_start_o and pix_req_o are low. The first clock edge after release presents line 1 at position 0.
- R2: line_start_o pulses for one cycle at the first output cycle of every line, once every LINE_CYC cycles. frame_start_o pulses only together with the line_start_o of line 1, once every FRAME_LINES lines.
- R3: Level codes on code_o[2:0] are: 000 sync, 001 blank, 010 black, 111 white. Codes 101 and 110 never appear.
- R4: Lines 1–3 and 7–9 are equalizing lines. They carry sync (000) for EQ cycles at positions 0 and HALF, and blank (001) elsewhere. HALF is LINE_CYC/2 rounded down, and EQ is 2.3 µs in cycles.
- R5: Lines 4–6 are broad-pulse lines. They carry sync for BROAD cycles (27.1 µs) at positions 0 and HALF, and blank elsewhere.
- R6: Lines from 10 on start with a front porch at blank, then horizontal sync (4.7 µs), then a back porch at blank (4.7 µs), then the image segment (52.6 µs). The front porch is the line length minus the other three, so it absorbs the rounding.
- R7: On lines 10–19 the image segment stays at blank.
- R8: Picture lines outside the image band, and any image cycles after the last pixel, are sent at black (010). With the default 263-line frame and 192 image lines, the band is lines 46–237.
- R9: On image lines the segment holds NPIX slots of PIX_CYC cycles each, with NPIX = image cycles / PIX_CYC rounded down. pix_req_o is high for one cycle, one cycle before each slot appears on code_o. The value captured then is held for the whole slot, and pix_i has no effect at other times.
- R10: Gray mapping of pix_i is 00 to 010, 01 to 100, 10 to 011 and 11 to 111.
- R11: If pix_rdy_i is low in the cycle pix_req_o is high, that slot is sent at black.
- R12: Every duration is ns × CLK_HZ / 10^9 rounded to the nearest cycle. For example, CLK_HZ = 2 MHz gives a 127-cycle line, a 4-cycle front porch, 9-cycle sync and back porch, a 22-cycle image start and 52 two-cycle pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of frequency CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_i | input | 2 | Gray pixel value from the pixel source |
| pix_rdy_i | input | 1 | Pixel source has a valid pixel on pix_i |
| pix_req_o | output | 1 | Pixel is taken this cycle for the next slot |
| code_o | output | 3 | Level code to the resistor network |
| line_start_o | output | 1 | First output cycle of a line |
| frame_start_o | output | 1 | First output cycle of line 1 |

## Verification
A wrong horizontal count shifts every sync and porch edge on code_o within one line. It also moves the line_start_o spacing away from LINE_CYC at the very next line boundary. A wrong line count or class decode shows up as a sync pattern or a black/blank level on the wrong line, and the frame_start_o period drifts within one frame. A pixel phase or hold error changes pix_req_o timing or the gray code inside a slot on the first image line. This is why the bench compares every output cycle of a full frame against a model built from the requirements.

// File: rtl/ntsc_mono_pkg.sv
package ntsc_mono_pkg;

  typedef enum logic [2:0] {
    LVL_SYNC  = 3'b000,
    LVL_BLANK = 3'b001,
    LVL_BLACK = 3'b010,
    LVL_DARK  = 3'b100,
    LVL_LIGHT = 3'b011,
    LVL_WHITE = 3'b111
  } level_e;

  typedef enum logic [2:0] {
    LC_EQ,
    LC_BROAD,
    LC_VBLANK,
    LC_BORDER,
    LC_IMAGE
  } line_cls_e;

  // fixed vertical interval layout (1-based line numbers)
  localparam int unsigned EQ1_LAST    = 3;
  localparam int unsigned BROAD_LAST  = 6;
  localparam int unsigned EQ2_LAST    = 9;
  localparam int unsigned VBLANK_LAST = 19;

  // nominal durations in ns
  localparam longint unsigned T_LINE_NS  = 63550;
  localparam longint unsigned T_EQ_NS    = 2300;
  localparam longint unsigned T_BROAD_NS = 27100;
  localparam longint unsigned T_HS_NS    = 4700;
  localparam longint unsigned T_BP_NS    = 4700;
  localparam longint unsigned T_IMG_NS   = 52600;

  function automatic int unsigned ns2cyc(longint unsigned ns, longint unsigned hz);
    return int'((ns * hz + 64'd500_000_000) / 64'd1_000_000_000);
  endfunction

  function automatic level_e gray2level(logic [1:0] g);
    case (g)
      2'b00:   return LVL_BLACK;
      2'b01:   return LVL_DARK;
      2'b10:   return LVL_LIGHT;
      default: return LVL_WHITE;
    endcase
  endfunction

endpackage

// File: rtl/raster_h_timer.sv
module raster_h_timer #(
  parameter int unsigned LINE_CYC = 1716,
  localparam int unsigned HW = $clog2(LINE_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic          eol_o
);

  localparam logic [HW-1:0] H_LAST = HW'(LINE_CYC - 1);

  logic [HW-1:0] h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            h_q <= '0;
    else if (h_q == H_LAST) h_q <= '0;
    else                    h_q <= h_q + HW'(1);
  end

  assign h_o   = h_q;
  assign eol_o = (h_q == H_LAST);

  AST_H_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |=> (h_o == '0)); // R2
  AST_H_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_o <= H_LAST); // R2

endmodule

// File: rtl/raster_v_timer.sv
module raster_v_timer
  import ntsc_mono_pkg::*;
#(
  parameter int unsigned FRAME_LINES = 263,
  parameter int unsigned IMG_FIRST   = 46,
  parameter int unsigned IMG_LAST    = 237,
  localparam int unsigned VW = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [VW-1:0] line_o,
  output line_cls_e     cls_o
);

  localparam logic [VW-1:0] L_LAST = VW'(FRAME_LINES);

  logic [VW-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    line_q <= VW'(1);
    else if (adv_i) line_q <= (line_q == L_LAST) ? VW'(1) : line_q + VW'(1);
  end

  always_comb begin
    if (line_q <= VW'(EQ1_LAST))                                   cls_o = LC_EQ;
    else if (line_q <= VW'(BROAD_LAST))                            cls_o = LC_BROAD;
    else if (line_q <= VW'(EQ2_LAST))                              cls_o = LC_EQ;
    else if (line_q <= VW'(VBLANK_LAST))                           cls_o = LC_VBLANK;
    else if (line_q >= VW'(IMG_FIRST) && line_q <= VW'(IMG_LAST))  cls_o = LC_IMAGE;
    else                                                           cls_o = LC_BORDER;
  end

  assign line_o = line_q;

  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o >= VW'(1)) && (line_o <= L_LAST)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && line_o == L_LAST) |=> (line_o == VW'(1))); // R2
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(line_o)); // R2

endmodule

// File: rtl/raster_level.sv
module raster_level
  import ntsc_mono_pkg::*;
#(
  parameter int unsigned LINE_CYC  = 1716,
  parameter int unsigned EQ_CYC    = 62,
  parameter int unsigned BROAD_CYC = 732,
  parameter int unsigned FP_CYC    = 42,
  parameter int unsigned HS_CYC    = 127,
  parameter int unsigned BP_CYC    = 127,
  parameter int unsigned PIX_CYC   = 4,
  parameter int unsigned NPIX      = 355,
  localparam int unsigned HW = $clog2(LINE_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] h_i,
  input  line_cls_e     cls_i,
  input  logic [1:0]    pix_i,
  input  logic          pix_rdy_i,
  output logic          pix_req_o,
  output logic [2:0]    code_o
);

  localparam int unsigned HALF_CYC  = LINE_CYC / 2;
  localparam int unsigned IMG_START = FP_CYC + HS_CYC + BP_CYC;
  localparam int unsigned PIX_END   = IMG_START + NPIX * PIX_CYC;

  localparam logic [HW-1:0] H_HALF    = HW'(HALF_CYC);
  localparam logic [HW-1:0] H_EQ_END  = HW'(EQ_CYC);
  localparam logic [HW-1:0] H_EQ2_END = HW'(HALF_CYC + EQ_CYC);
  localparam logic [HW-1:0] H_BR_END  = HW'(BROAD_CYC);
  localparam logic [HW-1:0] H_BR2_END = HW'(HALF_CYC + BROAD_CYC);
  localparam logic [HW-1:0] H_FP_END  = HW'(FP_CYC);
  localparam logic [HW-1:0] H_HS_END  = HW'(FP_CYC + HS_CYC);
  localparam logic [HW-1:0] H_IMG     = HW'(IMG_START);
  localparam logic [HW-1:0] H_PIX_END = HW'(PIX_END);

  logic   in_pix, slot_start;
  level_e hold_q, new_lvl, pix_lvl, code_d, code_q;

  assign in_pix = (cls_i == LC_IMAGE) && (h_i >= H_IMG) && (h_i < H_PIX_END);

  generate
    if (PIX_CYC == 1) begin : g_pix_single
      assign slot_start = 1'b1;
    end else begin : g_pix_phase
      localparam int unsigned PW = $clog2(PIX_CYC);
      logic [PW-1:0] phase_q, cur_phase;
      assign cur_phase  = (h_i == H_IMG) ? '0 : phase_q;
      assign slot_start = (cur_phase == '0);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= (cur_phase == PW'(PIX_CYC - 1)) ? '0 : cur_phase + PW'(1);
      end

      AST_REQ_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_req_o |=> !pix_req_o); // R9
    end
  endgenerate

  assign pix_req_o = in_pix && slot_start;
  assign new_lvl   = pix_rdy_i ? gray2level(pix_i) : LVL_BLACK;
  assign pix_lvl   = pix_req_o ? new_lvl : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= LVL_BLACK;
    else if (pix_req_o) hold_q <= new_lvl;
  end

  always_comb begin
    code_d = LVL_BLANK;
    case (cls_i)
      LC_EQ:
        if (h_i < H_EQ_END || (h_i >= H_HALF && h_i < H_EQ2_END)) code_d = LVL_SYNC;
      LC_BROAD:
        if (h_i < H_BR_END || (h_i >= H_HALF && h_i < H_BR2_END)) code_d = LVL_SYNC;
      default: begin
        if (h_i < H_FP_END)      code_d = LVL_BLANK;
        else if (h_i < H_HS_END) code_d = LVL_SYNC;
        else if (h_i < H_IMG)    code_d = LVL_BLANK;
        else if (cls_i == LC_VBLANK) code_d = LVL_BLANK;
        else if (in_pix)         code_d = pix_lvl;
        else                     code_d = LVL_BLACK;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= LVL_BLANK;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != 3'b101) && (code_o != 3'b110)); // R3
  AST_REQ_SHOWS_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |=> (code_o != 3'b000) && (code_o != 3'b001)); // R9
  AST_NO_REQ_OFF_IMAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i != LC_IMAGE) |-> !pix_req_o); // R8

endmodule

// File: rtl/ntsc_mono_raster.sv
module ntsc_mono_raster
  import ntsc_mono_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 27_000_000,
  parameter int unsigned PIX_CYC     = 4,
  parameter int unsigned FRAME_LINES = 263,
  parameter int unsigned IMG_LINES   = 192
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pix_i,
  input  logic       pix_rdy_i,
  output logic       pix_req_o,
  output logic [2:0] code_o,
  output logic       line_start_o,
  output logic       frame_start_o
);

  localparam int unsigned LINE_CYC  = ns2cyc(T_LINE_NS, CLK_HZ);
  localparam int unsigned EQ_CYC    = ns2cyc(T_EQ_NS, CLK_HZ);
  localparam int unsigned BROAD_CYC = ns2cyc(T_BROAD_NS, CLK_HZ);
  localparam int unsigned HS_CYC    = ns2cyc(T_HS_NS, CLK_HZ);
  localparam int unsigned BP_CYC    = ns2cyc(T_BP_NS, CLK_HZ);
  localparam int unsigned IMG_CYC   = ns2cyc(T_IMG_NS, CLK_HZ);
  localparam int unsigned FP_CYC    = LINE_CYC - HS_CYC - BP_CYC - IMG_CYC;
  localparam int unsigned NPIX      = IMG_CYC / PIX_CYC;
  localparam int unsigned IMG_FIRST = VBLANK_LAST + 1 + (FRAME_LINES - VBLANK_LAST - IMG_LINES) / 2;
  localparam int unsigned IMG_LAST  = IMG_FIRST + IMG_LINES - 1;
  localparam int unsigned HW        = $clog2(LINE_CYC);
  localparam int unsigned VW        = $clog2(FRAME_LINES + 1);

  logic [HW-1:0] h;
  logic          eol;
  logic [VW-1:0] line;
  line_cls_e     cls;
  logic          line_start_q, frame_start_q;

  raster_h_timer #(.LINE_CYC(LINE_CYC)) u_h (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .h_o    (h),
    .eol_o  (eol)
  );

  raster_v_timer #(
    .FRAME_LINES (FRAME_LINES),
    .IMG_FIRST   (IMG_FIRST),
    .IMG_LAST    (IMG_LAST)
  ) u_v (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (eol),
    .line_o (line),
    .cls_o  (cls)
  );

  raster_level #(
    .LINE_CYC  (LINE_CYC),
    .EQ_CYC    (EQ_CYC),
    .BROAD_CYC (BROAD_CYC),
    .FP_CYC    (FP_CYC),
    .HS_CYC    (HS_CYC),
    .BP_CYC    (BP_CYC),
    .PIX_CYC   (PIX_CYC),
    .NPIX      (NPIX)
  ) u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_i       (h),
    .cls_i     (cls),
    .pix_i     (pix_i),
    .pix_rdy_i (pix_rdy_i),
    .pix_req_o (pix_req_o),
    .code_o    (code_o)
  );

  // strobes registered to line up with code_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_start_q  <= 1'b0;
      frame_start_q <= 1'b0;
    end else begin
      line_start_q  <= (h == '0);
      frame_start_q <= (h == '0) && (line == VW'(1));
    end
  end

  assign line_start_o  = line_start_q;
  assign frame_start_o = frame_start_q;

  AST_FRAME_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_start_o); // R2
  AST_LINE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !line_start_o); // R2
  AST_SYNC_AT_LINE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o && line == VW'(1) && h == HW'(1)) |-> (code_o == 3'b000)); // R4

endmodule

// File: tb/ntsc_mono_raster_tb.sv
module ntsc_mono_raster_tb;

  // hand-derived counts for CLK_HZ = 2 MHz, PIX_CYC = 2 (R12)
  localparam int LINE = 127;
  localparam int HALF = 63;
  localparam int EQS  = 5;
  localparam int BRS  = 54;
  localparam int FP   = 4;
  localparam int HS   = 9;
  localparam int IMS  = 22;
  localparam int PEND = 126;
  localparam int FRM  = 263;
  localparam int IMG0 = 46;
  localparam int IMG1 = 237;

  typedef struct packed {
    logic [8:0] ln;
    logic [7:0] h;
    logic [2:0] code;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{9'd2,   8'd0,   3'b000, 4'd4},   // R4
    '{9'd2,   8'd4,   3'b000, 4'd4},   // R4
    '{9'd2,   8'd5,   3'b001, 4'd4},   // R4
    '{9'd2,   8'd63,  3'b000, 4'd4},   // R4
    '{9'd2,   8'd67,  3'b000, 4'd4},   // R4
    '{9'd2,   8'd68,  3'b001, 4'd4},   // R4
    '{9'd8,   8'd64,  3'b000, 4'd4},   // R4
    '{9'd9,   8'd126, 3'b001, 4'd4},   // R4
    '{9'd5,   8'd53,  3'b000, 4'd5},   // R5
    '{9'd5,   8'd54,  3'b001, 4'd5},   // R5
    '{9'd5,   8'd62,  3'b001, 4'd5},   // R5
    '{9'd5,   8'd63,  3'b000, 4'd5},   // R5
    '{9'd5,   8'd116, 3'b000, 4'd5},   // R5
    '{9'd5,   8'd117, 3'b001, 4'd5},   // R5
    '{9'd15,  8'd3,   3'b001, 4'd6},   // R6
    '{9'd15,  8'd4,   3'b000, 4'd6},   // R6
    '{9'd15,  8'd12,  3'b000, 4'd6},   // R6
    '{9'd15,  8'd13,  3'b001, 4'd6},   // R6
    '{9'd15,  8'd21,  3'b001, 4'd6},   // R6
    '{9'd15,  8'd22,  3'b001, 4'd7},   // R7
    '{9'd19,  8'd100, 3'b001, 4'd7},   // R7
    '{9'd45,  8'd60,  3'b010, 4'd8},   // R8
    '{9'd238, 8'd22,  3'b010, 4'd8},   // R8
    '{9'd263, 8'd126, 3'b010, 4'd8},   // R8
    '{9'd46,  8'd126, 3'b010, 4'd8},   // R8
    '{9'd46,  8'd22,  3'b011, 4'd10},  // R10
    '{9'd46,  8'd24,  3'b111, 4'd10},  // R10
    '{9'd46,  8'd26,  3'b010, 4'd10},  // R10
    '{9'd46,  8'd29,  3'b100, 4'd10},  // R10
    '{9'd237, 8'd22,  3'b100, 4'd10},  // R10
    '{9'd46,  8'd23,  3'b011, 4'd9},   // R9 hold
    '{9'd100, 8'd36,  3'b010, 4'd11},  // R11
    '{9'd100, 8'd37,  3'b010, 4'd11},  // R11
    '{9'd100, 8'd34,  3'b011, 4'd11}   // R11
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pix_i = 2'b00;
  logic       pix_rdy_i = 1'b1;
  logic       pix_req_o;
  logic [2:0] code_o;
  logic       line_start_o, frame_start_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  ntsc_mono_raster #(
    .CLK_HZ (2_000_000),
    .PIX_CYC(2)
  ) u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pix_i         (pix_i),
    .pix_rdy_i     (pix_rdy_i),
    .pix_req_o     (pix_req_o),
    .code_o        (code_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o)
  );

  task automatic chk(string rq, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] pat_val(int ln, int p);
    return 2'((p + ln) & 3);
  endfunction

  function automatic bit pat_rdy(int ln, int p);
    return !(ln == 100 && p == 7);
  endfunction

  function automatic logic [2:0] map_gray(logic [1:0] g);
    case (g)
      2'd0: return 3'b010;
      2'd1: return 3'b100;
      2'd2: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic bit is_img_slot(int ln, int h);
    return ln >= IMG0 && ln <= IMG1 && h >= IMS && h < PEND;
  endfunction

  function automatic logic [2:0] exp_code(int ln, int h);
    int p;
    if ((ln >= 1 && ln <= 3) || (ln >= 7 && ln <= 9))
      return (h < EQS || (h >= HALF && h < HALF + EQS)) ? 3'b000 : 3'b001;
    if (ln >= 4 && ln <= 6)
      return (h < BRS || (h >= HALF && h < HALF + BRS)) ? 3'b000 : 3'b001;
    if (h < FP) return 3'b001;
    if (h < FP + HS) return 3'b000;
    if (h < IMS) return 3'b001;
    if (ln <= 19) return 3'b001;
    if (!is_img_slot(ln, h)) return 3'b010;
    p = (h - IMS) / 2;
    if (!pat_rdy(ln, p)) return 3'b010;
    return map_gray(pat_val(ln, p));
  endfunction

  // runs cnt output cycles starting at position 0 (line 1) right after reset release
  task automatic sweep(int cnt);
    for (int n = 0; n < cnt; n++) begin
      int ln, h, ln2, h2;
      ln  = (n / LINE) % FRM + 1;
      h   = n % LINE;
      ln2 = ((n + 1) / LINE) % FRM + 1;
      h2  = (n + 1) % LINE;
      @(posedge clk_i);
      @(negedge clk_i);
      chk("R3", code_o, exp_code(ln, h), "code_o");
      chk("R2", line_start_o, (h == 0), "line_start_o");
      chk("R2", frame_start_o, (h == 0 && ln == 1), "frame_start_o");
      chk("R9", pix_req_o, is_img_slot(ln2, h2) && ((h2 - IMS) % 2 == 0), "pix_req_o");
      for (int k = 0; k < NV; k++) begin
        if (int'(VEC[k].ln) == ln && int'(VEC[k].h) == h)
          chk($sformatf("R%0d", VEC[k].rq), code_o, VEC[k].code, "table code_o");
      end
      // drive pixel for the position the next edge consumes; off-slot cycles get a wrong value
      if (is_img_slot(ln2, h2) && ((h2 - IMS) % 2 == 0)) begin
        pix_i     = pat_val(ln2, (h2 - IMS) / 2);
        pix_rdy_i = pat_rdy(ln2, (h2 - IMS) / 2);
      end else begin
        pix_i     = ~pat_val(ln2, (h2 - IMS) / 2);
        pix_rdy_i = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1", code_o, 3'b001, "reset code_o");
    chk("R1", line_start_o, 0, "reset line_start_o");
    chk("R1", frame_start_o, 0, "reset frame_start_o");
    chk("R1", pix_req_o, 0, "reset pix_req_o");
    rst_ni = 1'b1;
    // full frame plus one line; also checks R12 counts via hand-derived model
    sweep(FRM * LINE + LINE);
    // mid-frame reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", code_o, 3'b001, "async reset code_o");
    chk("R1", line_start_o, 0, "async reset line_start_o");
    @(negedge clk_i);
    chk("R1", pix_req_o, 0, "held reset pix_req_o");
    chk("R1", frame_start_o, 0, "held reset frame_start_o");
    rst_ni = 1'b1;
    sweep(3 * LINE);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150_000) @(posedge clk_i);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule